// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is a synchronous static memory with an input data bus and an output data bus kept apart. Every access moves a pair of words, and each access occupies one bus cycle. The block runs on one clock at twice the bus rate. An input phase bit tells the block whether the coming rising edge is the first-half edge (the K edge) or the second-half edge (the K# edge) of the bus cycle. A read and a write share one address bus. The read address is taken on the K edge and the write address on the K# edge, so one read burst and one write burst can start in the same bus cycle.

Write data arrives on both edges of the write cycle. The first word goes to the even word of the addressed pair and the second word to the odd word. Each word carries its own set of active-low lane enables, one per 9-bit lane. Read data comes back as two words with a valid flag. A static mode input picks the timing reference for the output. In the output-clock mode, the first word is aligned to a second-half edge. In the input-clock mode, both words follow the input clock edges one half period earlier.

Top module: `ddr_burst_sram`

## Requirements
- R1: With `k_half`=1 and `rd_n`=0 at a rising edge (a K edge), the block starts a read of word pair `addr`. It returns word `{addr,0}` first and word `{addr,1}` second.
- R2: With `wr_n`=0 at a K edge, a write starts. The write address is taken from `addr` at the next edge (the K# edge, `k_half`=0). Data and enables from the K edge go to word `{wa,0}`, and data and enables from the K# edge go to word `{wa,1}`.
- R3: `ben_n[i]`=0 writes lane i, which is bits [9i+8:9i] of the word. `ben_n[i]`=1 leaves that lane unchanged. The enables of the two beats are independent.
- R4: When `rd_n`=`wr_n`=1 at a K edge, the cycle is a no-op. The address, data and enables of that cycle change no stored word and raise no valid.
- R5: With `out_on_kclk`=0, the first read word is on `rdata` with `rd_valid`=1 after the 3rd rising edge following the read's K edge. The second word follows after the 4th. `rd_valid` is 0 whenever no read word is due.
- R6: With `out_on_kclk`=1, the first read word appears after the 2nd rising edge following the read's K edge, and the second word after the 3rd.
- R7: A read and a write to the same pair in the same bus cycle return the newly written lanes, merged with the old contents of the disabled lanes.
- R8: Reads issued on consecutive bus cycles give an unbroken valid stream of words in issue order.
- R9: After reset, `rd_valid`=0 and `rdata`=0.
- R10: A read and a write to different pairs in one bus cycle both complete. The read returns the old contents of its own pair.
- R11: The strobes are looked at only on K edges. Their values at K# edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| k_half | input | 1 | 1: the next rising edge is a K edge; 0: it is a K# edge |
| rd_n | input | 1 | Active-low read strobe, sampled on K edges |
| wr_n | input | 1 | Active-low write strobe, sampled on K edges |
| addr | input | AW | Word-pair address: read address on K edges, write address on K# edges |
| wdata | input | DW | Write data, one beat per edge |
| ben_n | input | DW/9 | Active-low lane write enables, one per 9-bit lane per beat |
| out_on_kclk | input | 1 | Static output timing select: 1 aligns read words to input-clock edges |
| rdata | output | DW | Read data word |
| rd_valid | output | 1 | High while `rdata` holds a read word |

## Verification
The bench first writes known data to every pair. It then applies directed and random mixes of reads, writes, combined read-and-write cycles and no-ops over a narrow address range, so that collisions are frequent. A same-pair read and write with opposing lane masks separates correct per-lane merging and read-after-write ordering from stale reads or whole-word writes. No-op cycles driven with live addresses, data and zero enables separate a design that ignores them from one that leaks writes. Both timing modes are run with single and back-to-back reads, which separates a half-period latency error from a beat-order error. Random strobe values during K# halves expose any sampling on the wrong edge.

// File: rtl/ddr_burst_sram_pkg.sv
package ddr_burst_sram_pkg;
  // Width of one byte lane guarded by its own write enable.
  localparam int LANE_BITS = 9;

  function automatic int lane_count(input int dw);
    return dw / LANE_BITS;
  endfunction
endpackage

// File: rtl/ddr_burst_sram_capture.sv
module ddr_burst_sram_capture
  import ddr_burst_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_half,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] ben_n,
  output logic          rd_go,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_d0,
  output logic [NB-1:0] wr_b0,
  output logic [DW-1:0] wr_d1,
  output logic [NB-1:0] wr_b1
);

  logic          rd_go_q, rd_go_d;
  logic [AW-1:0] ra_q, ra_d;
  logic          wr_go_q, wr_go_d;
  logic [DW-1:0] wd0_q, wd0_d;
  logic [NB-1:0] wb0_q, wb0_d;

  // Next state: commands and first write beat are taken on K edges only.
  always_comb begin
    rd_go_d = rd_go_q;
    ra_d    = ra_q;
    wr_go_d = 1'b0;
    wd0_d   = wd0_q;
    wb0_d   = wb0_q;
    if (k_half) begin
      rd_go_d = ~rd_n;
      if (!rd_n) ra_d = addr;
      wr_go_d = ~wr_n;
      if (!wr_n) begin
        wd0_d = wdata;
        wb0_d = ben_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_go_q <= 1'b0;
      ra_q    <= '0;
      wr_go_q <= 1'b0;
      wd0_q   <= '0;
      wb0_q   <= '1;
    end else begin
      rd_go_q <= rd_go_d;
      ra_q    <= ra_d;
      wr_go_q <= wr_go_d;
      wd0_q   <= wd0_d;
      wb0_q   <= wb0_d;
    end
  end

  // Write commit happens on the K# edge; address and second beat come live.
  assign rd_go   = rd_go_q;
  assign rd_addr = ra_q;
  assign wr_en   = wr_go_q & ~k_half;
  assign wr_addr = addr;
  assign wr_d0   = wd0_q;
  assign wr_b0   = wb0_q;
  assign wr_d1   = wdata;
  assign wr_b1   = ben_n;

  // R2
  wr_pending_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go_q |-> !k_half);

endmodule

// File: rtl/ddr_burst_sram_array.sv
module ddr_burst_sram_array
  import ddr_burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  parameter int NB    = 4,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_d0,
  input  logic [NB-1:0] wr_b0,
  input  logic [DW-1:0] wr_d1,
  input  logic [NB-1:0] wr_b1,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_w0,
  output logic [DW-1:0] rd_w1
);

  localparam int WORDS = 2 * DEPTH;
  localparam int LW    = DW / NB;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] mask0, mask1;

  // Expand the active-low lane enables into bit masks.
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign mask0[g*LW +: LW] = {LW{~wr_b0[g]}};
    assign mask1[g*LW +: LW] = {LW{~wr_b1[g]}};
  end

  // Storage is not reset; both words of the pair update in one edge.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[{wr_addr, 1'b0}] <= (mem[{wr_addr, 1'b0}] & ~mask0) | (wr_d0 & mask0);
      mem[{wr_addr, 1'b1}] <= (mem[{wr_addr, 1'b1}] & ~mask1) | (wr_d1 & mask1);
    end
  end

  assign rd_w0 = mem[{rd_addr, 1'b0}];
  assign rd_w1 = mem[{rd_addr, 1'b1}];

endmodule

// File: rtl/ddr_burst_sram_rd_align.sv
module ddr_burst_sram_rd_align #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_half,
  input  logic          kmode,
  input  logic          rd_go,
  input  logic [DW-1:0] rd_w0,
  input  logic [DW-1:0] rd_w1,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);

  logic [DW-1:0] pw0_q, pw0_d, pw1_q, pw1_d;
  logic          ld_q, ld_d;
  logic          c1_q, c1_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          vld_q, vld_d;

  // Pair is captured on the K edge after the read, once the same-cycle
  // write has landed in the array.
  always_comb begin
    pw0_d   = pw0_q;
    pw1_d   = pw1_q;
    ld_d    = 1'b0;
    c1_d    = 1'b0;
    rdata_d = rdata_q;
    vld_d   = 1'b0;
    if (k_half) begin
      if (rd_go) begin
        pw0_d = rd_w0;
        pw1_d = rd_w1;
      end
      ld_d = rd_go;
      if (kmode && rd_go) begin
        rdata_d = rd_w0;
        vld_d   = 1'b1;
      end else if (!kmode && c1_q) begin
        rdata_d = pw1_q;
        vld_d   = 1'b1;
      end
    end else if (ld_q) begin
      rdata_d = kmode ? pw1_q : pw0_q;
      vld_d   = 1'b1;
      c1_d    = ~kmode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw0_q   <= '0;
      pw1_q   <= '0;
      ld_q    <= 1'b0;
      c1_q    <= 1'b0;
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      pw0_q   <= pw0_d;
      pw1_q   <= pw1_d;
      ld_q    <= ld_d;
      c1_q    <= c1_d;
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = vld_q;

  // R5
  two_beat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |=> vld_q);

  // R6
  load_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> !k_half);

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddr_burst_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 36,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = lane_count(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_half,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] ben_n,
  input  logic          out_on_kclk,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);

  logic          rd_go;
  logic [AW-1:0] rd_addr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_d0, wr_d1;
  logic [NB-1:0] wr_b0, wr_b1;
  logic [DW-1:0] rd_w0, rd_w1;

  ddr_burst_sram_capture #(.AW(AW), .DW(DW), .NB(NB)) u_cap (
    .clk(clk), .rst_n(rst_n), .k_half(k_half), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .ben_n(ben_n),
    .rd_go(rd_go), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_d0(wr_d0), .wr_b0(wr_b0), .wr_d1(wr_d1), .wr_b1(wr_b1)
  );

  ddr_burst_sram_array #(.DEPTH(DEPTH), .DW(DW), .NB(NB), .AW(AW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_d0(wr_d0), .wr_b0(wr_b0), .wr_d1(wr_d1), .wr_b1(wr_b1),
    .rd_addr(rd_addr), .rd_w0(rd_w0), .rd_w1(rd_w1)
  );

  ddr_burst_sram_rd_align #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .k_half(k_half), .kmode(out_on_kclk),
    .rd_go(rd_go), .rd_w0(rd_w0), .rd_w1(rd_w1),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  // R5
  out_clk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k_half && !rd_n && !out_on_kclk) |-> ##4 rd_valid);

  // R6
  in_clk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (k_half && !rd_n && out_on_kclk) |-> ##3 rd_valid);

endmodule

// File: tb/tb_ddr_burst_sram.sv
`timescale 1ns/1ps
module tb_ddr_burst_sram;
  localparam int DEPTH = 256;
  localparam int DW    = 36;
  localparam int AW    = 8;
  localparam int NB    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          k_half;
  logic          rd_n, wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NB-1:0] ben_n;
  logic          out_on_kclk;
  logic [DW-1:0] rdata;
  logic          rd_valid;

  ddr_burst_sram #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .k_half(k_half), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .ben_n(ben_n), .out_on_kclk(out_on_kclk),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;

  logic [DW-1:0] model [2*DEPTH];
  bit            exp_v [16];
  logic [DW-1:0] exp_d [16];
  string         exp_t [16];
  int            ecnt = 0;
  int            checks = 0;
  int            fails = 0;
  bit            chk_on = 1'b0;
  int            slot;

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at edge %0d", tag, act, exp, ecnt);
    end
  endtask

  // Output sampler, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      slot = ecnt % 16;
      if (exp_v[slot]) begin
        check({exp_t[slot], " valid"}, DW'(rd_valid), DW'(1));
        check({exp_t[slot], " data"}, rdata, exp_d[slot]);
      end else begin
        check("R5 idle valid", DW'(rd_valid), DW'(0));
      end
      exp_v[slot] = 1'b0;
    end
  end

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NB; l++)
      if (!be[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  // One bus cycle: K half then K# half.
  task automatic bus(input bit rd, input bit wr, input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [NB-1:0] b0, input logic [NB-1:0] b1, input string tag);
    int ke;
    int off;
    @(negedge clk);
    k_half = 1'b1; rd_n = ~rd; wr_n = ~wr; addr = ra; wdata = d0; ben_n = b0;
    @(negedge clk);
    ke = ecnt;
    // R11: strobe values on the K# half are random and must not matter
    k_half = 1'b0; rd_n = 1'($urandom()); wr_n = 1'($urandom());
    addr = wa; wdata = d1; ben_n = b1;
    @(posedge clk);
    #1;
    if (wr) begin
      model[{wa, 1'b0}] = merge(model[{wa, 1'b0}], d0, b0);
      model[{wa, 1'b1}] = merge(model[{wa, 1'b1}], d1, b1);
    end
    if (rd) begin
      off = out_on_kclk ? 2 : 3;
      exp_v[(ke + off) % 16] = 1'b1;
      exp_d[(ke + off) % 16] = model[{ra, 1'b0}];
      exp_t[(ke + off) % 16] = {tag, " word0"};
      exp_v[(ke + off + 1) % 16] = 1'b1;
      exp_d[(ke + off + 1) % 16] = model[{ra, 1'b1}];
      exp_t[(ke + off + 1) % 16] = {tag, " word1"};
    end
  endtask

  task automatic rd_only(input logic [AW-1:0] a, input string tag);
    bus(1'b1, 1'b0, a, AW'($urandom()), rnd_word(), rnd_word(), NB'($urandom()), NB'($urandom()), tag);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++)
      bus(1'b0, 1'b0, AW'($urandom()), AW'($urandom()), rnd_word(), rnd_word(), '0, '0, "R4");
  endtask

  task automatic random_mix(input int n, input string tag);
    for (int i = 0; i < n; i++)
      bus(($urandom() % 3) != 0, ($urandom() % 2) != 0, AW'($urandom() % 16), AW'($urandom() % 16),
          rnd_word(), rnd_word(), NB'($urandom()), NB'($urandom()), tag);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a7));
    rst_n = 1'b0; k_half = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; wdata = '0; ben_n = '1; out_on_kclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 valid after reset", DW'(rd_valid), DW'(0));
    check("R9 data after reset", rdata, '0);
    chk_on = 1'b1;

    // R2: fill every pair with both beats fully enabled
    for (int i = 0; i < DEPTH; i++)
      bus(1'b0, 1'b1, '0, AW'(i), rnd_word(), rnd_word(), '0, '0, "R2");

    // R1 and R8: back-to-back reads, output-clock timing (R5)
    for (int i = 0; i < 8; i++) rd_only(AW'(i), "R1 R8 R5");
    nop(3);

    // R7 and R3: same-pair read and write with opposing lane masks
    bus(1'b1, 1'b1, 8'd20, 8'd20, rnd_word(), rnd_word(), 4'b1010, 4'b0101, "R7 R3");
    rd_only(8'd20, "R7 R3 reread");
    // R10: read one pair while writing another
    bus(1'b1, 1'b1, 8'd30, 8'd31, rnd_word(), rnd_word(), 4'b0000, 4'b1110, "R10");
    rd_only(8'd31, "R10 written pair");

    // R4: no-op cycles with live address, data and enables
    for (int i = 0; i < 4; i++)
      bus(1'b0, 1'b0, AW'(40 + i), AW'(40 + i), rnd_word(), rnd_word(), '0, '0, "R4");
    for (int i = 0; i < 4; i++) rd_only(AW'(40 + i), "R4 unchanged");
    nop(3);

    random_mix(1500, "R1 random out-clk");
    nop(4);

    // R6: input-clock alignment
    out_on_kclk = 1'b1;
    rd_only(8'd5, "R6 single");
    nop(3);
    for (int i = 0; i < 6; i++) rd_only(AW'(100 + i), "R6 R8");
    bus(1'b1, 1'b1, 8'd60, 8'd60, rnd_word(), rnd_word(), 4'b0110, 4'b1001, "R6 R7");
    random_mix(1500, "R6 random");
    nop(4);

    out_on_kclk = 1'b0;
    random_mix(500, "R5 random");
    nop(4);

    chk_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule